// File: doc/BRIEF.md
# DDR2 Extended-Mode Strobe and DLL Lock Gate

This block sits on the device side of a DDR2-style memory. It watches mode-register-set commands and captures the ones aimed at extended register 1. From the captured value it keeps four settings: the DLL disable bit, the single-ended strobe select, the read-strobe enable and the output-off bit. It also follows self-refresh entry and exit, and counts the wait the DLL needs to resynchronise after each restart.

Read commands pass through a gate. A read is accepted only when the DLL is on, the device is out of self-refresh, and a full lock wait has run since the last DLL restart. Otherwise the read is rejected. During the data phase of a read, the block produces the output enables for the strobe, its complement, the read strobe and its complement. It also tells the write path whether the data-mask input is live. The device width is fixed by a parameter, and only the x8 variant has the read strobe.

Top module: `ddr2_emr_dll_ctrl`

## Requirements
- R1: The extended register loads only when `mrsCmd` is high, `bankSel` is 2'b01 (bit 0 high, bit 1 low), and every address bit from 13 upward is 0. Any other mode command leaves all settings unchanged.
- R2: Loading a 1 in address bit 0 turns the DLL off. `dllActive` drops, and every read is rejected until a load with bit 0 at 0 is made.
- R3: An accepted load with address bit 0 at 0 restarts the DLL. A read sampled on the LOCK_CYCLES-th rising edge after the load edge, or on any later edge, is accepted. A read sampled on an earlier edge is rejected. After reset, reads are rejected until the first such restart has finished its wait.
- R4: Pulsing `selfRefEnter` turns the DLL off with no command. While self-refresh lasts, `dllActive` is 0, reads are rejected and no pin enable is driven.
- R5: Pulsing `selfRefExit` turns the DLL back on and restarts the lock wait. The same LOCK_CYCLES timing as R3 applies, counted from the exit edge.
- R6: Each read command produces exactly one pulse, on `rdAccepted` or on `rdRejected`, in the cycle after it is sampled. No pulse appears without a read.
- R7: When address bit 12 (output off) was loaded as 1, all pin enables stay 0 during `rdBurst`.
- R8: During `rdBurst` with output off clear, `dqsOe` is 1. `dqsCompOe` is 1 only when address bit 10 was loaded as 0 (differential strobe). Bit 10 set to 1 gives a single-ended strobe.
- R9: On x8 with address bit 11 loaded as 1, `rdqsOe` follows `dqsOe`, `rdqsCompOe` follows `dqsCompOe`, and `dmInputEn` is 0. With bit 11 at 0, both read-strobe enables are 0 and `dmInputEn` is 1.
- R10: On widths other than x8, address bit 11 has no effect. The read-strobe enables stay 0 and `dmInputEn` stays 1.
- R11: After reset, all settings are 0. In this state the DLL is on, `lockWaiting` is 1, `dmInputEn` is 1 and every pin enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mrsCmd | input | 1 | Mode-register-set command strobe |
| bankSel | input | 2 | Bank address that comes with the command |
| addrIn | input | ADDR_W | Address bus; carries the register value |
| selfRefEnter | input | 1 | Self-refresh entry pulse |
| selfRefExit | input | 1 | Self-refresh exit pulse |
| rdCmd | input | 1 | Read command strobe |
| rdBurst | input | 1 | Read data phase in progress |
| rdAccepted | output | 1 | Read was forwarded (one cycle after `rdCmd`) |
| rdRejected | output | 1 | Read was blocked (one cycle after `rdCmd`) |
| dllActive | output | 1 | DLL is currently on |
| lockWaiting | output | 1 | A lock wait is still running, or none has completed yet |
| dqsOe | output | 1 | Strobe output enable |
| dqsCompOe | output | 1 | Complement strobe output enable |
| rdqsOe | output | 1 | Read strobe output enable |
| rdqsCompOe | output | 1 | Complement read strobe output enable |
| dmInputEn | output | 1 | Data-mask input function live |

## Verification
The hardest case to reach is the exact edge of the lock window after a self-refresh exit. Reaching it needs a fully locked DLL, a self-refresh entry, a read rejected in self-refresh and an exit, and only then can the reads be timed against the exit edge. The stimulus builds that chain in order. It then places one read on the edge just before the window closes and one on the edge where the window closes, and does the same after a restart by register load. A second instance built for x16 shares the same inputs, so the read-strobe setting can be shown to have no effect there.

// File: rtl/ddr2_emr_pkg.sv
package ddr2_emr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic emrLoad;   // capture register fields this edge
    logic pinDrive;  // read data phase while device is awake
  } emrStrobe_t;
endpackage

// File: rtl/ddr2_emr_ctrl.sv
module ddr2_emr_ctrl
  import ddr2_emr_pkg::*;
#(
  parameter int LOCK_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mrsCmd,
  input  logic [1:0] bankSel,
  input  logic       highClear,
  input  logic       dllEnBitLow,
  input  logic       dllDis,
  input  logic       selfRefEnter,
  input  logic       selfRefExit,
  input  logic       rdCmd,
  input  logic       rdBurst,
  output emrStrobe_t str,
  output logic       rdAccepted,
  output logic       rdRejected,
  output logic       dllActive,
  output logic       lockWaiting
);
  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES - 1);

  logic             srActive;
  logic             armed;
  logic [CNT_W-1:0] lockCnt;
  logic             emrHit;
  logic             dllRestart;
  logic             lockDone;
  logic             rdOk;

  assign emrHit     = mrsCmd && (bankSel == 2'b01) && highClear;
  assign dllRestart = (emrHit && dllEnBitLow) || selfRefExit;
  assign lockDone   = armed && (lockCnt == '0);
  assign dllActive  = !dllDis && !srActive;
  assign lockWaiting = !lockDone;
  assign rdOk       = dllActive && lockDone;

  assign str.emrLoad  = emrHit;
  assign str.pinDrive = rdBurst && !srActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srActive <= 1'b0;
    end else if (selfRefExit) begin
      srActive <= 1'b0;
    end else if (selfRefEnter) begin
      srActive <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      lockCnt <= '0;
    end else if (dllRestart) begin
      armed   <= 1'b1;
      lockCnt <= CNT_LOAD;
    end else if (lockCnt != '0) begin
      lockCnt <= lockCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAccepted <= 1'b0;
      rdRejected <= 1'b0;
    end else begin
      rdAccepted <= rdCmd && rdOk;
      rdRejected <= rdCmd && !rdOk;
    end
  end
endmodule

// File: rtl/ddr2_emr_datapath.sv
module ddr2_emr_datapath
  import ddr2_emr_pkg::*;
#(
  parameter int DEV_WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  emrStrobe_t str,
  input  logic       aDllDis,
  input  logic       aDqsSingle,
  input  logic       aRdqsEn,
  input  logic       aQoff,
  output logic       dllDis,
  output logic       dqsOe,
  output logic       dqsCompOe,
  output logic       rdqsOe,
  output logic       rdqsCompOe,
  output logic       dmInputEn
);
  logic dqsSingle;
  logic qoff;
  logic rdqsLive;
  logic drive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dllDis    <= 1'b0;
      dqsSingle <= 1'b0;
      qoff      <= 1'b0;
    end else if (str.emrLoad) begin
      dllDis    <= aDllDis;
      dqsSingle <= aDqsSingle;
      qoff      <= aQoff;
    end
  end

  generate
    if (DEV_WIDTH == 8) begin : g_rdqs
      logic rdqsEn;
      always_ff @(posedge clk) begin
        if (!rstN) rdqsEn <= 1'b0;
        else if (str.emrLoad) rdqsEn <= aRdqsEn;
      end
      assign rdqsLive = rdqsEn;
    end else begin : g_nordqs
      logic unusedRdqsBit;
      assign unusedRdqsBit = aRdqsEn;
      assign rdqsLive = 1'b0;
    end
  endgenerate

  assign drive      = str.pinDrive && !qoff;
  assign dqsOe      = drive;
  assign dqsCompOe  = drive && !dqsSingle;
  assign rdqsOe     = drive && rdqsLive;
  assign rdqsCompOe = drive && rdqsLive && !dqsSingle;
  assign dmInputEn  = !rdqsLive;
endmodule

// File: rtl/ddr2_emr_dll_ctrl.sv
module ddr2_emr_dll_ctrl
  import ddr2_emr_pkg::*;
#(
  parameter int DEV_WIDTH   = 8,
  parameter int ADDR_W      = 14,
  parameter int LOCK_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsCmd,
  input  logic [1:0]        bankSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selfRefEnter,
  input  logic              selfRefExit,
  input  logic              rdCmd,
  input  logic              rdBurst,
  output logic              rdAccepted,
  output logic              rdRejected,
  output logic              dllActive,
  output logic              lockWaiting,
  output logic              dqsOe,
  output logic              dqsCompOe,
  output logic              rdqsOe,
  output logic              rdqsCompOe,
  output logic              dmInputEn
);
  localparam int HIGH_LSB = 13;

  emrStrobe_t str;
  logic       dllDis;
  logic       highClear;
  logic       unusedAddr;

  assign highClear  = (addrIn[ADDR_W-1:HIGH_LSB] == '0);
  assign unusedAddr = ^addrIn[9:1];

  ddr2_emr_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .mrsCmd(mrsCmd), .bankSel(bankSel),
    .highClear(highClear), .dllEnBitLow(!addrIn[0]), .dllDis(dllDis),
    .selfRefEnter(selfRefEnter), .selfRefExit(selfRefExit),
    .rdCmd(rdCmd), .rdBurst(rdBurst), .str(str),
    .rdAccepted(rdAccepted), .rdRejected(rdRejected),
    .dllActive(dllActive), .lockWaiting(lockWaiting)
  );

  ddr2_emr_datapath #(.DEV_WIDTH(DEV_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .aDllDis(addrIn[0]), .aDqsSingle(addrIn[10]),
    .aRdqsEn(addrIn[11]), .aQoff(addrIn[12]),
    .dllDis(dllDis), .dqsOe(dqsOe), .dqsCompOe(dqsCompOe),
    .rdqsOe(rdqsOe), .rdqsCompOe(rdqsCompOe), .dmInputEn(dmInputEn)
  );
endmodule

// File: rtl/ddr2_emr_dll_chk.sv
module ddr2_emr_dll_chk #(
  parameter int DEV_WIDTH = 8
) (
  input logic clk,
  input logic rstN,
  input logic rdCmd,
  input logic selfRefEnter,
  input logic selfRefExit,
  input logic rdAccepted,
  input logic rdRejected,
  input logic dllActive,
  input logic lockWaiting,
  input logic dqsOe,
  input logic dqsCompOe,
  input logic rdqsOe,
  input logic rdqsCompOe,
  input logic dmInputEn
);
  a_r6_one_result: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAccepted && rdRejected));
  a_r6_result_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    rdCmd |=> (rdAccepted || rdRejected));
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !rdCmd |=> !(rdAccepted || rdRejected));
  a_r3_wait_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && lockWaiting) |=> rdRejected);
  a_r2_off_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && !dllActive) |=> rdRejected);
  a_r4_enter_off: assert property (@(posedge clk) disable iff (!rstN)
    (selfRefEnter && !selfRefExit) |=> !dllActive);
  a_r4_sr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (selfRefEnter && !selfRefExit) |=> !dqsOe);
  a_r5_exit_restarts: assert property (@(posedge clk) disable iff (!rstN)
    selfRefExit |=> (lockWaiting && dllActive));
  a_r8_comp_needs_true: assert property (@(posedge clk) disable iff (!rstN)
    dqsCompOe |-> dqsOe);
  a_r9_rdqs_pairing: assert property (@(posedge clk) disable iff (!rstN)
    (rdqsCompOe |-> rdqsOe) and (rdqsOe |-> (dqsOe && !dmInputEn)));

  generate
    if (DEV_WIDTH != 8) begin : g_r10
      a_r10_no_rdqs: assert property (@(posedge clk) disable iff (!rstN)
        !rdqsOe && !rdqsCompOe && dmInputEn);
    end
  endgenerate
endmodule

bind ddr2_emr_dll_ctrl ddr2_emr_dll_chk #(.DEV_WIDTH(DEV_WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .selfRefEnter(selfRefEnter),
  .selfRefExit(selfRefExit), .rdAccepted(rdAccepted), .rdRejected(rdRejected),
  .dllActive(dllActive), .lockWaiting(lockWaiting), .dqsOe(dqsOe),
  .dqsCompOe(dqsCompOe), .rdqsOe(rdqsOe), .rdqsCompOe(rdqsCompOe),
  .dmInputEn(dmInputEn)
);

// File: tb/ddr2_emr_dll_ctrl_tb.sv
module ddr2_emr_dll_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 200;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mrsCmd = 1'b0;
  logic [1:0] bankSel = 2'b00;
  logic [AW-1:0] addrIn = '0;
  logic selfRefEnter = 1'b0, selfRefExit = 1'b0, rdCmd = 1'b0, rdBurst = 1'b0;
  logic rdAccepted, rdRejected, dllActive, lockWaiting;
  logic dqsOe, dqsCompOe, rdqsOe, rdqsCompOe, dmInputEn;
  logic acc16, rej16, dll16, lw16, dqs16, dqsc16, rdqs16, rdqsc16, dm16;

  int checks = 0;
  int failures = 0;
  bit expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_emr_dll_ctrl #(.DEV_WIDTH(8), .ADDR_W(AW), .LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rstN(rstN), .mrsCmd(mrsCmd), .bankSel(bankSel), .addrIn(addrIn),
    .selfRefEnter(selfRefEnter), .selfRefExit(selfRefExit), .rdCmd(rdCmd),
    .rdBurst(rdBurst), .rdAccepted(rdAccepted), .rdRejected(rdRejected),
    .dllActive(dllActive), .lockWaiting(lockWaiting), .dqsOe(dqsOe),
    .dqsCompOe(dqsCompOe), .rdqsOe(rdqsOe), .rdqsCompOe(rdqsCompOe),
    .dmInputEn(dmInputEn));

  ddr2_emr_dll_ctrl #(.DEV_WIDTH(16), .ADDR_W(AW), .LOCK_CYCLES(LOCK)) u_dut16 (
    .clk(clk), .rstN(rstN), .mrsCmd(mrsCmd), .bankSel(bankSel), .addrIn(addrIn),
    .selfRefEnter(selfRefEnter), .selfRefExit(selfRefExit), .rdCmd(rdCmd),
    .rdBurst(rdBurst), .rdAccepted(acc16), .rdRejected(rej16),
    .dllActive(dll16), .lockWaiting(lw16), .dqsOe(dqs16),
    .dqsCompOe(dqsc16), .rdqsOe(rdqs16), .rdqsCompOe(rdqsc16),
    .dmInputEn(dm16));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic emrWrite(input logic [1:0] ba, input logic [AW-1:0] a);
    mrsCmd = 1'b1; bankSel = ba; addrIn = a;
    @(negedge clk);
    mrsCmd = 1'b0; bankSel = 2'b00; addrIn = '0;
  endtask

  // driver: pushes the expected outcome, then issues one read
  task automatic doRead(input bit expAccept, input string tag);
    expQ.push_back(expAccept);
    tagQ.push_back(tag);
    rdCmd = 1'b1;
    @(negedge clk);
    rdCmd = 1'b0;
  endtask

  // pin enables in order dqs, dqsComp, rdqs, rdqsComp, dmIn
  task automatic checkPins(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    rdBurst = 1'b1;
    #1;
    act = {dqsOe, dqsCompOe, rdqsOe, rdqsCompOe, dmInputEn};
    check(act == exp, tag, int'(act), int'(exp));
    @(negedge clk);
    rdBurst = 1'b0;
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rstN && (rdAccepted || rdRejected)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected result", int'(rdAccepted), 0);
      end else begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check((rdAccepted == e) && (rdRejected == !e), t, int'(rdAccepted), int'(e));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R11 reset state
    check(dllActive && lockWaiting && dmInputEn, "R11 reset flags", int'({dllActive, lockWaiting, dmInputEn}), 7);
    check({dqsOe, dqsCompOe, rdqsOe, rdqsCompOe} == 4'b0, "R11 pins idle", int'({dqsOe, dqsCompOe, rdqsOe, rdqsCompOe}), 0);
    doRead(1'b0, "R3 read before first lock");

    // R1 writes that must be ignored (try to disable DLL)
    emrWrite(2'b00, 14'h0001); idle(1);
    check(dllActive, "R1 wrong bank ignored", int'(dllActive), 1);
    emrWrite(2'b11, 14'h0001); idle(1);
    check(dllActive, "R1 both banks ignored", int'(dllActive), 1);
    emrWrite(2'b01, 14'h2001); idle(1);
    check(dllActive, "R1 high bit set ignored", int'(dllActive), 1);

    // R3 lock window after enable load
    emrWrite(2'b01, 14'h0000);
    check(lockWaiting, "R3 waiting after restart", int'(lockWaiting), 1);
    idle(LOCK - 2);
    doRead(1'b0, "R3 read one edge early");
    doRead(1'b1, "R3 read on window edge");
    check(!lockWaiting, "R3 wait over", int'(lockWaiting), 0);
    check(!dqsOe, "R8 no drive without burst", int'(dqsOe), 0);
    checkPins(5'b11001, "R8 differential default");

    // R8 single-ended, R9 rdqs on x8
    emrWrite(2'b01, 14'h0400); idle(1);
    checkPins(5'b10001, "R8 single-ended");
    emrWrite(2'b01, 14'h0800); idle(1);
    checkPins(5'b11110, "R9 rdqs differential");
    check(!dm16 && 1'b0 || dm16, "R10 x16 dm live", int'(dm16), 1);
    rdBurst = 1'b1; #1;
    check(!rdqs16 && !rdqsc16 && dqs16, "R10 x16 rdqs ignored", int'({rdqs16, rdqsc16, dqs16}), 1);
    @(negedge clk); rdBurst = 1'b0;
    emrWrite(2'b01, 14'h0C00); idle(1);
    checkPins(5'b10100, "R9 rdqs single-ended");
    // R7 output off
    emrWrite(2'b01, 14'h1C00); idle(1);
    checkPins(5'b00000, "R7 output off");

    // R2 DLL disable
    emrWrite(2'b01, 14'h0001); idle(1);
    check(!dllActive, "R2 dll off", int'(dllActive), 0);
    idle(LOCK);
    doRead(1'b0, "R2 read with dll off");

    // R4 / R5 self-refresh
    emrWrite(2'b01, 14'h0000);
    idle(LOCK);
    doRead(1'b1, "R3 relocked");
    selfRefEnter = 1'b1; @(negedge clk); selfRefEnter = 1'b0;
    check(!dllActive, "R4 dll off in self-refresh", int'(dllActive), 0);
    doRead(1'b0, "R4 read in self-refresh");
    checkPins(5'b00001, "R4 pins quiet in self-refresh");
    selfRefExit = 1'b1; @(negedge clk); selfRefExit = 1'b0;
    check(dllActive && lockWaiting, "R5 exit restarts", int'({dllActive, lockWaiting}), 3);
    idle(LOCK - 2);
    doRead(1'b0, "R5 read one edge early");
    doRead(1'b1, "R5 read on window edge");

    idle(3);
    check(expQ.size() == 0, "R6 missing results", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule